// File: doc/BRIEF.md
# Host Keyboard Controller Interface Port

This block sits between an asynchronous ISA-style host bus and an embedded controller core that plays the part of a keyboard controller. The host sees two byte-wide locations. One address bit chooses between them: a command/status location and a data location. The host accesses them with an active-low select and separate active-low read and write strobes. The core sees an input buffer holding the last byte the host wrote, an output buffer it loads for the host to fetch, and two full flags.

Host strobes are resynchronised into the core clock domain. Each strobe takes effect exactly once, when it is released. A host write fills the input buffer and records whether the byte was a command or data. When the core consumes the byte, the input-full flag clears. When the core loads the output buffer, an active-high output-full pin rises. The pin falls only after the host finishes a read of the data location.

Top module: `kbcHostPort`

## Requirements
- R1: After reset, the input buffer, the output buffer, input-full, output-full and the command flag are all zero, so a status read and a data read both return 0x00.
- R2: A host write (select low, write strobe low, then released) latches the data bus byte into the input buffer and sets input-full. Both appear on the third core clock edge after the strobe is released.
- R3: The address bit seen during a host write is stored as the command flag, with 1 for a command and 0 for data. It is reported in status bit 3.
- R4: A one-cycle core read pulse clears input-full on the next clock edge. If a host write completes in the same cycle, input-full stays set.
- R5: A one-cycle core load pulse copies the core data into the output buffer and raises the output-full pin on the next clock edge.
- R6: While the host reads with the address bit at 0, the data bus shows the output buffer. Output-full clears on the third core clock edge after that read strobe is released.
- R7: While the host reads with the address bit at 1, the data bus shows the status byte: bit 0 is output-full, bit 1 is input-full, bit 3 is the command flag, and every other bit is 0. Completing a status read leaves output-full unchanged.
- R8: Read and write strobes have no effect while the select input is high.
- R9: A strobe held low for many cycles causes exactly one action, and only after it is released. Input-full stays clear while a write strobe is still held low.
- R10: If a core load and the completion of a host data read fall in the same cycle, output-full stays set and the new byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostCsN | input | 1 | Host select, active low |
| hostRdN | input | 1 | Host read strobe, active low |
| hostWrN | input | 1 | Host write strobe, active low |
| hostAddr | input | 1 | Location select: 1 command/status, 0 data |
| hostDin | input | 8 | Byte written by the host |
| hostDout | output | 8 | Byte presented to the host (status or output buffer) |
| coreInRead | input | 1 | One-cycle pulse: core has taken the input buffer |
| coreInData | output | 8 | Input buffer contents |
| coreInIsCmd | output | 1 | Command flag of the last host write |
| coreInFull | output | 1 | Input-full flag |
| coreOutLoad | input | 1 | One-cycle pulse: load the output buffer |
| coreOutData | input | 8 | Byte to load into the output buffer |
| outFull | output | 1 | Output-full pin, active high |

## Verification
Effects of a host strobe appear on the third core edge after release: two synchroniser stages, then the edge-detect register, then the flag or buffer register. The bench therefore waits four falling edges after each release before sampling. Core pulses act on the next rising edge, so their results are sampled at the falling edge that follows. The same-cycle collisions of R4 and R10 are produced by raising the core pulse exactly two falling edges after the host strobe is released, which places it in the cycle where the completion event is live. Host read data is a combinational view and is sampled while the read strobe is held low.

// File: rtl/kbcPkg.sv
package kbcPkg;
  typedef struct packed {
    logic wrCapture;   // synchronised write strobe active: sample host byte
    logic wrDone;      // host write completed this cycle
    logic wrIsCmd;     // address bit that went with the write
    logic rdDataDone;  // host data-location read completed this cycle
    logic coreRd;      // core consumed input buffer
    logic coreLoad;    // core loads output buffer
  } ctrlStrobes_t;

  localparam int STAT_OUT_FULL = 0;
  localparam int STAT_IN_FULL  = 1;
  localparam int STAT_CMD      = 3;
endpackage

// File: rtl/kbcSync.sv
module kbcSync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  for (genvar b = 0; b < WIDTH; b++) begin : gBit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], asyncIn[b]};
    end
    assign syncOut[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/kbcCtrl.sv
module kbcCtrl
  import kbcPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hostCsN,
  input  logic         hostRdN,
  input  logic         hostWrN,
  input  logic         hostAddr,
  input  logic         coreInRead,
  input  logic         coreOutLoad,
  output ctrlStrobes_t strb
);
  localparam int N_STROBES = 2;
  localparam int IDX_WR = 0;
  localparam int IDX_RD = 1;

  logic [N_STROBES-1:0] rawAct, act, actPrev, doneEv;
  logic addrHold;

  assign rawAct[IDX_WR] = ~hostCsN & ~hostWrN;
  assign rawAct[IDX_RD] = ~hostCsN & ~hostRdN;

  kbcSync #(.WIDTH(N_STROBES), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(rawAct), .syncOut(act)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actPrev  <= '0;
      addrHold <= 1'b0;
    end else begin
      actPrev <= act;
      if (|act) addrHold <= hostAddr;
    end
  end

  assign doneEv = actPrev & ~act;

  always_comb begin
    strb.wrCapture  = act[IDX_WR];
    strb.wrDone     = doneEv[IDX_WR];
    strb.wrIsCmd    = addrHold;
    strb.rdDataDone = doneEv[IDX_RD] & ~addrHold;
    strb.coreRd     = coreInRead;
    strb.coreLoad   = coreOutLoad;
  end

  // R9: a completion event lasts a single cycle
  a_r9_single_write_event: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrDone |=> !strb.wrDone);
  a_r9_single_read_event: assert property (@(posedge clk) disable iff (!rstN)
    doneEv[IDX_RD] |=> !doneEv[IDX_RD]);
endmodule

// File: rtl/kbcDatapath.sv
module kbcDatapath
  import kbcPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic              hostAddr,
  input  logic [DATA_W-1:0] hostDin,
  output logic [DATA_W-1:0] hostDout,
  input  logic [DATA_W-1:0] coreOutData,
  output logic [DATA_W-1:0] coreInData,
  output logic              coreInIsCmd,
  output logic              coreInFull,
  output logic              outFull
);
  logic [DATA_W-1:0] hostByte, inBuf, outBuf, statusByte;
  logic ibf, obf, cmdFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostByte <= '0;
      inBuf    <= '0;
      outBuf   <= '0;
      ibf      <= 1'b0;
      obf      <= 1'b0;
      cmdFlag  <= 1'b0;
    end else begin
      if (strb.wrCapture) hostByte <= hostDin;
      if (strb.wrDone) begin
        inBuf   <= hostByte;
        cmdFlag <= strb.wrIsCmd;
      end
      if (strb.wrDone)      ibf <= 1'b1;
      else if (strb.coreRd) ibf <= 1'b0;
      if (strb.coreLoad) outBuf <= coreOutData;
      if (strb.coreLoad)        obf <= 1'b1;
      else if (strb.rdDataDone) obf <= 1'b0;
    end
  end

  always_comb begin
    statusByte = '0;
    statusByte[STAT_OUT_FULL] = obf;
    statusByte[STAT_IN_FULL]  = ibf;
    statusByte[STAT_CMD]      = cmdFlag;
  end

  assign hostDout    = hostAddr ? statusByte : outBuf;
  assign coreInData  = inBuf;
  assign coreInIsCmd = cmdFlag;
  assign coreInFull  = ibf;
  assign outFull     = obf;

  a_r2_write_sets_full: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrDone |=> coreInFull);
  a_r4_core_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strb.coreRd && !strb.wrDone) |=> !coreInFull);
  a_r5_load_sets_full: assert property (@(posedge clk) disable iff (!rstN)
    strb.coreLoad |=> (outFull && hostDout == $past(coreOutData)) || hostAddr);
  a_r6_data_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdDataDone && !strb.coreLoad) |=> !outFull);
  a_r7_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    (outFull && !strb.rdDataDone) |=> outFull);
endmodule

// File: rtl/kbcHostPort.sv
module kbcHostPort
  import kbcPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCsN,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic              hostAddr,
  input  logic [DATA_W-1:0] hostDin,
  output logic [DATA_W-1:0] hostDout,
  input  logic              coreInRead,
  output logic [DATA_W-1:0] coreInData,
  output logic              coreInIsCmd,
  output logic              coreInFull,
  input  logic              coreOutLoad,
  input  logic [DATA_W-1:0] coreOutData,
  output logic              outFull
);
  ctrlStrobes_t strb;

  kbcCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .hostCsN(hostCsN), .hostRdN(hostRdN),
    .hostWrN(hostWrN), .hostAddr(hostAddr), .coreInRead(coreInRead),
    .coreOutLoad(coreOutLoad), .strb(strb)
  );

  kbcDatapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .hostAddr(hostAddr),
    .hostDin(hostDin), .hostDout(hostDout), .coreOutData(coreOutData),
    .coreInData(coreInData), .coreInIsCmd(coreInIsCmd),
    .coreInFull(coreInFull), .outFull(outFull)
  );
endmodule

// File: tb/kbcHostPort_test.sv
module kbcHostPort_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostCsN = 1'b1, hostRdN = 1'b1, hostWrN = 1'b1, hostAddr = 1'b0;
  logic [7:0] hostDin = '0;
  logic [7:0] hostDout, coreInData, coreOutData = '0;
  logic coreInRead = 1'b0, coreOutLoad = 1'b0;
  logic coreInIsCmd, coreInFull, outFull;
  int total = 0, bad = 0;
  logic [7:0] got;

  always #10 clk = ~clk;

  kbcHostPort uut (
    .clk(clk), .rstN(rstN), .hostCsN(hostCsN), .hostRdN(hostRdN),
    .hostWrN(hostWrN), .hostAddr(hostAddr), .hostDin(hostDin),
    .hostDout(hostDout), .coreInRead(coreInRead), .coreInData(coreInData),
    .coreInIsCmd(coreInIsCmd), .coreInFull(coreInFull),
    .coreOutLoad(coreOutLoad), .coreOutData(coreOutData), .outFull(outFull)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic hostWrite(input logic a, input logic [7:0] d, input logic cs);
    @(negedge clk);
    hostCsN = ~cs; hostAddr = a; hostDin = d; hostWrN = 1'b0;
    waitN(5);
    hostWrN = 1'b1; hostCsN = 1'b1;
    waitN(4);
  endtask

  task automatic hostRead(input logic a, input logic cs, output logic [7:0] v);
    @(negedge clk);
    hostCsN = ~cs; hostAddr = a; hostRdN = 1'b0;
    waitN(4);
    v = hostDout;
    hostRdN = 1'b1; hostCsN = 1'b1;
    waitN(4);
  endtask

  task automatic corePulse(input logic rd, input logic ld, input logic [7:0] d);
    coreInRead = rd; coreOutLoad = ld; coreOutData = d;
    @(negedge clk);
    coreInRead = 1'b0; coreOutLoad = 1'b0;
  endtask

  function automatic logic [7:0] statusOf(input logic obf, input logic ibf, input logic cmd);
    return {4'b0, cmd, 1'b0, ibf, obf};
  endfunction

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog: got hung expected done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    waitN(3);
    rstN = 1'b1;
    waitN(1);
    // R1 reset state
    chk("R1 inFull", {7'b0, coreInFull}, 8'h00);
    chk("R1 outFull", {7'b0, outFull}, 8'h00);
    chk("R1 inData", coreInData, 8'h00);
    hostAddr = 1'b1; #1; chk("R1 status", hostDout, 8'h00);
    hostAddr = 1'b0; #1; chk("R1 data", hostDout, 8'h00);

    // R2/R3/R4 sweep of all bytes, address alternating
    for (int v = 0; v < 256; v++) begin
      logic a;
      a = v[0] ^ v[3];
      hostWrite(a, 8'(v), 1'b1);
      chk("R2 inData", coreInData, 8'(v));
      chk("R2 inFull", {7'b0, coreInFull}, 8'h01);
      chk("R3 cmdFlag", {7'b0, coreInIsCmd}, {7'b0, a});
      corePulse(1'b1, 1'b0, 8'h00);
      chk("R4 cleared", {7'b0, coreInFull}, 8'h00);
    end

    // R3 status bit 3 and bit 1
    hostWrite(1'b1, 8'h5a, 1'b1);
    hostRead(1'b1, 1'b1, got);
    chk("R7 status cmd", got, statusOf(1'b0, 1'b1, 1'b1));
    corePulse(1'b1, 1'b0, 8'h00);

    // R5/R6/R7 sweep of output bytes
    for (int v = 0; v < 256; v++) begin
      corePulse(1'b0, 1'b1, 8'(255 - v));
      chk("R5 outFull", {7'b0, outFull}, 8'h01);
      hostRead(1'b1, 1'b1, got);
      chk("R7 status obf", got, statusOf(1'b1, 1'b0, 1'b1));
      chk("R7 kept", {7'b0, outFull}, 8'h01);
      hostRead(1'b0, 1'b1, got);
      chk("R6 data", got, 8'(255 - v));
      chk("R6 cleared", {7'b0, outFull}, 8'h00);
    end

    // R8 select high: write and read ignored
    corePulse(1'b0, 1'b1, 8'h3c);
    hostWrite(1'b0, 8'hc3, 1'b0);
    chk("R8 no write", {7'b0, coreInFull}, 8'h00);
    chk("R8 buffer kept", coreInData, 8'h5a);
    hostRead(1'b0, 1'b0, got);
    chk("R8 no read", {7'b0, outFull}, 8'h01);

    // R9 long strobe: nothing until release, then one action
    @(negedge clk);
    hostCsN = 1'b0; hostAddr = 1'b0; hostDin = 8'h77; hostWrN = 1'b0;
    waitN(20);
    chk("R9 held", {7'b0, coreInFull}, 8'h00);
    hostWrN = 1'b1; hostCsN = 1'b1;
    waitN(2);
    chk("R9 not yet", {7'b0, coreInFull}, 8'h00);
    waitN(1);
    chk("R9 third edge", {7'b0, coreInFull}, 8'h01);
    chk("R9 data", coreInData, 8'h77);
    corePulse(1'b1, 1'b0, 8'h00);
    waitN(5);
    chk("R9 once", {7'b0, coreInFull}, 8'h00);

    // R4 collision: core read in the write completion cycle
    @(negedge clk);
    hostCsN = 1'b0; hostAddr = 1'b1; hostDin = 8'h99; hostWrN = 1'b0;
    waitN(5);
    hostWrN = 1'b1; hostCsN = 1'b1;
    waitN(2);
    corePulse(1'b1, 1'b0, 8'h00);
    chk("R4 write wins", {7'b0, coreInFull}, 8'h01);
    corePulse(1'b1, 1'b0, 8'h00);

    // R10 collision: load in the data read completion cycle
    @(negedge clk);
    hostCsN = 1'b0; hostAddr = 1'b0; hostRdN = 1'b0;
    waitN(5);
    chk("R6 data view", hostDout, 8'h3c);
    hostRdN = 1'b1; hostCsN = 1'b1;
    waitN(2);
    corePulse(1'b0, 1'b1, 8'he1);
    waitN(3);
    chk("R10 full kept", {7'b0, outFull}, 8'h01);
    hostAddr = 1'b0; #1;
    chk("R10 new byte", hostDout, 8'he1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule